// File: doc/BRIEF.md
# Page Translation Cache with Line and Global Invalidation

This block is a small, fully associative store of recent virtual-to-physical page translations. It sits in front of a two-level table walker inside an address translation unit. Each lookup presents a 20-bit virtual page number, which is bits 31:12 of a 32-bit address for 4 KiB pages. One cycle later the block reports either a hit, with the physical page number and permission bits, or a miss. A miss raises a walk request carrying the same page number.

The walker returns its result through a fill port. A fill marked usable is written into the store. A fill marked unusable, meaning an invalid entry or a fault, is dropped, so a later retry walks the tables again. Software maintenance reaches the block through three commands:
- Remove one page by any address inside it. This is also how a stale translation for the first page of a newly installed second-level table is removed.
- Clear the whole store.
- Page-fault completion. This clears the whole store and then signals that the fault may be released.

The number of entries is a parameter. When no entry is free, the entry to replace is chosen round-robin.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid and `rs_valid`, `wk_req` and `fault_done` are 0.
- R2: A lookup with `lk_valid`=1 in cycle t gives `rs_valid`=1 in cycle t+1. On a hit, `rs_hit`=1 and `rs_ppn`/`rs_perm` hold the stored values. Results come out one per lookup, in issue order. A lookup sees the contents as they stood before any update made in the same cycle.
- R3: A lookup that misses gives `rs_hit`=0 together with `wk_req`=1, and `wk_vpn` equals the looked-up page number. `wk_req` is 0 in every other cycle.
- R4: A fill with `fill_ok`=1 stores tag, page number and permissions. A fill with `fill_ok`=0 stores nothing, so a later lookup of that tag misses.
- R5: A fill for a new tag takes the lowest-numbered free entry. When all entries are valid, it replaces entries in round-robin order starting at entry 0, and the pointer advances only on such replacements.
- R6: A fill whose tag is already stored updates that entry in place and evicts nothing.
- R7: `inv_valid` with `inv_addr` removes the entry whose tag equals `inv_addr[31:12]`. Bits 11:0 are ignored, and other entries are kept.
- R8: A line invalidation in the same cycle as a fill for the same tag wins, and the entry ends up invalid.
- R9: `inv_all` invalidates every entry in one cycle.
- R10: `pf_clear` invalidates every entry in one cycle. `fault_done` is 1 in the following cycle, and no entry is valid at that point.
- R11: A clear (`inv_all` or `pf_clear`) in the same cycle as a fill wins, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Virtual page number to look up |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Lookup hit |
| rs_ppn | output | 20 | Physical page number on hit |
| rs_perm | output | 2 | Permission bits on hit (bit 1 write, bit 0 read) |
| wk_req | output | 1 | Walk request on miss |
| wk_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Walk result strobe |
| fill_ok | input | 1 | Walk result usable (1) or invalid/faulted (0) |
| fill_vpn | input | 20 | Tag of the walk result |
| fill_ppn | input | 20 | Physical page number of the walk result |
| fill_perm | input | 2 | Permission bits of the walk result |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_addr | input | 32 | Any address inside the page to remove |
| inv_all | input | 1 | Invalidate every entry |
| pf_clear | input | 1 | Page-fault completion: invalidate all, then signal |
| fault_done | output | 1 | Fault may be released; store is empty |

## Verification
The bench builds the block with 4 entries, so the store fills after four distinct tags and round-robin replacement of entry 0, then entry 1, is reached within a few directed fills. Random traffic draws tags from a pool of eight, twice the entry count. That keeps eviction, in-place refresh, same-cycle invalidate/fill collisions and clears occurring often, with every lookup result compared against a bench model of the store.

// File: rtl/xc_pkg.sv
package xc_pkg;
  // Classification of a fill write, used by the update logic
  typedef enum logic [1:0] {
    FILL_NONE    = 2'd0,
    FILL_REFRESH = 2'd1,
    FILL_FREE    = 2'd2,
    FILL_EVICT   = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/xc_tag_match.sv
module xc_tag_match #(
  parameter int N = 8,
  parameter int W = 20
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     valid,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] victim,
  output logic             full
);
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign full   = !any_free;
  assign victim = any_free ? free_idx : rr_ptr;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic [PERM_W-1:0] rs_perm,
  output logic              wk_req,
  output logic [VPN_W-1:0]  wk_vpn,
  input  logic              fill_valid,
  input  logic              fill_ok,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              inv_all,
  input  logic              pf_clear,
  output logic              fault_done
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // Entry storage
  logic [ENTRIES-1:0]             v_q, v_d, v_f;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q, tag_d;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q, ppn_d;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q, perm_d;
  logic [IDX_W-1:0]               rr_q, rr_d;

  // Result registers
  logic              rs_valid_q, rs_hit_q, wk_req_q, fdone_q;
  logic [PPN_W-1:0]  rs_ppn_q, rs_ppn_d;
  logic [PERM_W-1:0] rs_perm_q, rs_perm_d;
  logic [VPN_W-1:0]  wk_vpn_q;

  logic [ENTRIES-1:0] lk_hit, fill_hit, inv_hit, fill_sel;
  logic [IDX_W-1:0]   victim;
  logic               full;
  logic               clr;
  logic [VPN_W-1:0]   inv_tag;
  fill_kind_e         fill_kind;

  assign clr     = inv_all || pf_clear;
  assign inv_tag = inv_addr[ADDR_W-1 -: VPN_W];

  xc_tag_match #(.N(ENTRIES), .W(VPN_W)) u_lk_match (
    .valid(v_q), .tags(tag_q), .key(lk_vpn), .hit(lk_hit)
  );

  xc_tag_match #(.N(ENTRIES), .W(VPN_W)) u_fill_match (
    .valid(v_q), .tags(tag_q), .key(fill_vpn), .hit(fill_hit)
  );

  // Invalidate compares against post-fill contents so a same-cycle fill loses
  xc_tag_match #(.N(ENTRIES), .W(VPN_W)) u_inv_match (
    .valid(v_f), .tags(tag_d), .key(inv_tag), .hit(inv_hit)
  );

  xc_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(v_q), .rr_ptr(rr_q), .victim(victim), .full(full)
  );

  // Fill stage: choose the target entry and write it
  always_comb begin
    fill_kind = FILL_NONE;
    fill_sel  = '0;
    rr_d      = rr_q;
    v_f       = v_q;
    tag_d     = tag_q;
    ppn_d     = ppn_q;
    perm_d    = perm_q;
    if (fill_valid && fill_ok && !clr) begin
      if (|fill_hit) begin
        fill_kind = FILL_REFRESH;
        fill_sel  = fill_hit;
      end else begin
        fill_kind = full ? FILL_EVICT : FILL_FREE;
        fill_sel  = ENTRIES'(1) << victim;
      end
    end
    if (fill_kind == FILL_EVICT) begin
      rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_sel[i]) begin
        v_f[i]    = 1'b1;
        tag_d[i]  = fill_vpn;
        ppn_d[i]  = fill_ppn;
        perm_d[i] = fill_perm;
      end
    end
  end

  // Invalidate stage: clears override everything, line invalidate overrides fill
  always_comb begin
    if (clr) begin
      v_d = '0;
    end else if (inv_valid) begin
      v_d = v_f & ~inv_hit;
    end else begin
      v_d = v_f;
    end
  end

  // Lookup read mux
  always_comb begin
    rs_ppn_d  = '0;
    rs_perm_d = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i]) begin
        rs_ppn_d  = rs_ppn_d | ppn_q[i];
        rs_perm_d = rs_perm_d | perm_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else begin
      v_q  <= v_d;
      rr_q <= rr_d;
    end
  end

  // Payload needs no reset: it is qualified by v_q
  always_ff @(posedge clk) begin
    tag_q  <= tag_d;
    ppn_q  <= ppn_d;
    perm_q <= perm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      wk_req_q   <= 1'b0;
      fdone_q    <= 1'b0;
    end else begin
      rs_valid_q <= lk_valid;
      rs_hit_q   <= lk_valid && (|lk_hit);
      wk_req_q   <= lk_valid && !(|lk_hit);
      fdone_q    <= pf_clear;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rs_ppn_q  <= rs_ppn_d;
      rs_perm_q <= rs_perm_d;
      wk_vpn_q  <= lk_vpn;
    end
  end

  assign rs_valid   = rs_valid_q;
  assign rs_hit     = rs_hit_q;
  assign rs_ppn     = rs_ppn_q;
  assign rs_perm    = rs_perm_q;
  assign wk_req     = wk_req_q;
  assign wk_vpn     = wk_vpn_q;
  assign fault_done = fdone_q;

  // ---------------- assertions ----------------
  logic             inv_chk_q;
  logic [VPN_W-1:0] inv_tag_q;
  logic             inv_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_chk_q <= 1'b0;
      inv_tag_q <= '0;
    end else begin
      inv_chk_q <= inv_valid;
      inv_tag_q <= inv_tag;
    end
  end

  always_comb begin
    inv_left = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i] && tag_q[i] == inv_tag_q) inv_left = 1'b1;
    end
  end

  a_r2_one_result_per_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  a_r2_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  a_r3_walk_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wk_req |-> (rs_valid && !rs_hit));
  a_r3_miss_requests_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> wk_req);
  a_r6_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));
  a_r7_line_removed: assert property (@(posedge clk) disable iff (!rst_n)
    inv_chk_q |-> !inv_left);
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (v_q == '0));
  a_r10_done_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fault_done |-> (v_q == '0));
  a_r10_done_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pf_clear |=> fault_done);
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, fill_ok, inv_valid, inv_all, pf_clear;
  logic [19:0] lk_vpn, fill_vpn, fill_ppn, wk_vpn, rs_ppn;
  logic [1:0]  fill_perm, rs_perm;
  logic [31:0] inv_addr;
  logic        rs_valid, rs_hit, wk_req, fault_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xlat_cache #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_ppn(rs_ppn), .rs_perm(rs_perm),
    .wk_req(wk_req), .wk_vpn(wk_vpn),
    .fill_valid(fill_valid), .fill_ok(fill_ok), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_all(inv_all), .pf_clear(pf_clear), .fault_done(fault_done)
  );

  // Reference model of the store
  bit          m_v[N];
  logic [19:0] m_tag[N];
  logic [19:0] m_ppn[N];
  logic [1:0]  m_perm[N];
  int          m_rr;

  function automatic void model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endfunction

  function automatic int model_find(logic [19:0] t);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void model_update();
    int j;
    if (inv_all || pf_clear) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      return;
    end
    if (fill_valid && fill_ok) begin
      j = model_find(fill_vpn);
      if (j < 0) begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) j = i;
      end
      if (j < 0) begin
        j = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[j] = 1; m_tag[j] = fill_vpn; m_ppn[j] = fill_ppn; m_perm[j] = fill_perm;
    end
    if (inv_valid) begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_tag[i] == inv_addr[31:12]) m_v[i] = 0;
    end
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0;
    fill_valid = 0; fill_ok = 0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0;
    inv_valid = 0; inv_addr = '0; inv_all = 0; pf_clear = 0;
  endtask

  // Apply current inputs for one cycle and check the results of that cycle
  task automatic tick(string rq);
    bit          e_lk, e_hit, e_fd;
    logic [19:0] e_ppn, e_vpn;
    logic [1:0]  e_perm;
    int          j;
    e_lk = lk_valid; e_fd = pf_clear; e_vpn = lk_vpn;
    j = model_find(lk_vpn);
    e_hit = (j >= 0);
    e_ppn  = e_hit ? m_ppn[j] : '0;
    e_perm = e_hit ? m_perm[j] : '0;
    model_update();
    @(posedge clk); #2;
    chk(rs_valid === e_lk, rq, "rs_valid", rs_valid, e_lk);
    chk(fault_done === e_fd, rq, "fault_done", fault_done, e_fd);
    if (e_lk) begin
      chk(rs_hit === e_hit, rq, "rs_hit", rs_hit, e_hit);
      if (e_hit) begin
        chk(rs_ppn === e_ppn, rq, "rs_ppn", rs_ppn, e_ppn);
        chk(rs_perm === e_perm, rq, "rs_perm", rs_perm, e_perm);
        chk(wk_req === 1'b0, rq, "wk_req", wk_req, 0);
      end else begin
        chk(wk_req === 1'b1, rq, "wk_req", wk_req, 1);
        chk(wk_vpn === e_vpn, rq, "wk_vpn", wk_vpn, e_vpn);
      end
    end else begin
      chk(wk_req === 1'b0, rq, "wk_req", wk_req, 0);
    end
    idle_inputs();
  endtask

  task automatic look(logic [19:0] t, string rq);
    lk_valid = 1; lk_vpn = t;
    tick(rq);
  endtask

  task automatic fill(logic [19:0] t, logic [19:0] p, logic [1:0] pm, bit ok, string rq);
    fill_valid = 1; fill_ok = ok; fill_vpn = t; fill_ppn = p; fill_perm = pm;
    tick(rq);
  endtask

  // Expect a hit or miss without relying on the model
  task automatic expect_look(logic [19:0] t, bit hit, logic [19:0] p, string rq);
    lk_valid = 1; lk_vpn = t;
    tick(rq);
    chk(rs_hit === hit, rq, "direct hit", rs_hit, hit);
    if (hit) chk(rs_ppn === p, rq, "direct ppn", rs_ppn, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1dc0ffee));
    idle_inputs();
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1: reset state
    tick("R1");
    chk(rs_valid === 0 && wk_req === 0 && fault_done === 0, "R1", "idle outs",
        {rs_valid, wk_req, fault_done}, 0);
    // R3: miss after reset
    expect_look(20'h12345, 0, '0, "R3");
    chk(wk_vpn === 20'h12345, "R3", "walk vpn", wk_vpn, 20'h12345);

    // R4, R2: fill then hit
    fill(20'h12345, 20'hABCDE, 2'b11, 1, "R4");
    expect_look(20'h12345, 1, 20'hABCDE, "R2");
    chk(rs_perm === 2'b11, "R2", "perm", rs_perm, 2'b11);
    // R4: unusable fill not stored
    fill(20'h00777, 20'h11111, 2'b01, 0, "R4");
    expect_look(20'h00777, 0, '0, "R4");

    // R5: fill to full, then round-robin from entry 0
    fill(20'h0000A, 20'h000A0, 2'b01, 1, "R5");
    fill(20'h0000B, 20'h000B0, 2'b10, 1, "R5");
    fill(20'h0000C, 20'h000C0, 2'b11, 1, "R5");
    fill(20'h0000E, 20'h000E0, 2'b01, 1, "R5");
    expect_look(20'h12345, 0, '0, "R5");
    expect_look(20'h0000A, 1, 20'h000A0, "R5");
    expect_look(20'h0000E, 1, 20'h000E0, "R5");
    fill(20'h0000F, 20'h000F0, 2'b01, 1, "R5");
    expect_look(20'h0000A, 0, '0, "R5");
    expect_look(20'h0000B, 1, 20'h000B0, "R5");

    // R6: refresh in place evicts nothing
    fill(20'h0000B, 20'h0BBBB, 2'b11, 1, "R6");
    expect_look(20'h0000B, 1, 20'h0BBBB, "R6");
    expect_look(20'h0000C, 1, 20'h000C0, "R6");
    expect_look(20'h0000E, 1, 20'h000E0, "R6");
    expect_look(20'h0000F, 1, 20'h000F0, "R6");

    // R7: line invalidate by an address with nonzero offset
    inv_valid = 1; inv_addr = {20'h0000B, 12'hFFF};
    tick("R7");
    expect_look(20'h0000B, 0, '0, "R7");
    expect_look(20'h0000C, 1, 20'h000C0, "R7");

    // R8: invalidate wins over same-cycle fill of the same tag
    fill_valid = 1; fill_ok = 1; fill_vpn = 20'h00042; fill_ppn = 20'h42000; fill_perm = 2'b11;
    inv_valid = 1; inv_addr = {20'h00042, 12'h004};
    tick("R8");
    expect_look(20'h00042, 0, '0, "R8");

    // R2: lookup sees old contents during same-cycle fill, back-to-back order
    lk_valid = 1; lk_vpn = 20'h00050;
    fill_valid = 1; fill_ok = 1; fill_vpn = 20'h00050; fill_ppn = 20'h05000; fill_perm = 2'b10;
    tick("R2");
    chk(rs_hit === 0, "R2", "same-cycle lookup", rs_hit, 0);
    expect_look(20'h00050, 1, 20'h05000, "R2");
    expect_look(20'h0000C, 1, 20'h000C0, "R2");

    // R9: invalidate all
    inv_all = 1;
    tick("R9");
    expect_look(20'h0000C, 0, '0, "R9");
    expect_look(20'h00050, 0, '0, "R9");

    // R10: fault completion clears and signals
    fill(20'h00060, 20'h06000, 2'b01, 1, "R10");
    pf_clear = 1;
    tick("R10");
    chk(fault_done === 1, "R10", "fault_done", fault_done, 1);
    expect_look(20'h00060, 0, '0, "R10");
    chk(fault_done === 0, "R10", "fault_done drop", fault_done, 0);

    // R11: clear beats same-cycle fill
    fill_valid = 1; fill_ok = 1; fill_vpn = 20'h00070; fill_ppn = 20'h07000; fill_perm = 2'b11;
    inv_all = 1;
    tick("R11");
    expect_look(20'h00070, 0, '0, "R11");

    // Random traffic, R2 to R11 against the model
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      lk_valid = ($urandom_range(0, 99) < 70);
      lk_vpn   = 20'($urandom_range(0, 7));
      if (r < 40) begin
        fill_valid = 1; fill_ok = ($urandom_range(0, 9) != 0);
        fill_vpn = 20'($urandom_range(0, 7));
        fill_ppn = 20'($urandom); fill_perm = 2'($urandom);
      end
      if (r >= 35 && r < 50) begin
        inv_valid = 1;
        inv_addr = {20'($urandom_range(0, 7)), 12'($urandom)};
      end
      if (r == 97) inv_all = 1;
      if (r == 98) pf_clear = 1;
      tick("R2 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule